// File: doc/BRIEF.md
# Audio Codec Control Register Bank

This block holds the control registers of an audio codec. A host reaches it through a single request port. Each request carries a 7-bit byte address and 16-bit data, and a request is either a read or a write. Read data comes back one cycle after the request.

Most registers are plain storage. A few registers apply their own write rules:

- The volume registers replicate their mute request bits into the attenuation fields.
- The power-down and extended-control registers accept writes only to some of their bits.
- The sample-rate registers accept a write only while variable-rate mode is enabled, and they round the written value to a supported rate.

The block also drives the playback settings that downstream audio logic needs: per-channel attenuation, a mute flag and the DAC rate. It raises a one-cycle reconfigure strobe whenever the playback rate must be re-applied.

Top module: `codec_regfile`

## Requirements
- R1: A cycle with `rst` high returns every register to its default and clears `rd_valid` and `reconfig`. The defaults are:
  - 0x02, 0x04, 0x06 and 0x1c read 0x8000.
  - 0x0c and 0x0e read 0x8008.
  - 0x10, 0x12, 0x14, 0x16 and 0x18 read 0x8808.
  - 0x26 reads 0x000f, 0x28 reads 0x0a05 and 0x2a reads 0x0400.
  - 0x2c and 0x32 read 48000.
  - Every other address reads 0, except the reset word and the vendor words (R2, R9).
- R2: A write of any value to address 0x00 restores every register to its R1 default and pulses `reconfig`. Address 0x00 always reads 0x6a90.
- R3: A write to the master volume at 0x02 is stored as follows. If data bit 13 is set, bits 12:8 become all ones. If data bit 5 is set, bits 4:0 become all ones. The result is then masked with 0x9f1f.
- R4: A write to the PCM-out volume at 0x18 is stored masked with 0x9f1f.
- R5: In the extended control register at 0x2a, only bit 0 (variable-rate enable) is writable, so the register reads 0x0400 | bit0. A write that clears bit 0 forces both rate registers to 48000 and pulses `reconfig`.
- R6: A write to the DAC rate (0x2c) or the ADC rate (0x32) while variable-rate enable is 0 is ignored, and `reconfig` stays low.
- R7: An accepted rate write is stored as a snapped value and pulses `reconfig`. The snapped value is:
  - 8000 below 9512
  - 11025 below 13512
  - 16000 below 19025
  - 22050 below 27025
  - 32000 below 38050
  - 44100 below 46050
  - 48000 otherwise
- R8: A write to the power-down register at 0x26 updates bits 15:8 only. Bits 7:0 always read 0x0f.
- R9: Writes to 0x28, 0x7c and 0x7e are dropped. 0x7c and 0x7e read the parameters `VEND_ID_HI` and `VEND_ID_LO`.
- R10: Every other address is plain 16-bit storage. Address bit 0 is ignored, so an odd address selects the word below it.
- R11: The outputs follow the master volume M and the PCM-out volume P:
  - `att_left` is min(31, M[12:8] + P[12:8]).
  - `att_right` is min(31, M[4:0] + P[4:0]).
  - `mute` is M[15] | P[15].
  - `dac_rate` is the DAC rate register.
  - The outputs and `reconfig` change two clock edges after the write request is sampled.
- R12: A read request sampled at one edge drives `rd_valid` high with `rd_data` after that edge, for one cycle. `rd_valid` is low after any edge that did not sample a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address (bit 0 ignored) |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| att_left | output | 5 | Left attenuation, saturated |
| att_right | output | 5 | Right attenuation, saturated |
| mute | output | 1 | Combined mute flag |
| dac_rate | output | 16 | Current DAC sample rate |
| reconfig | output | 1 | One-cycle reconfigure strobe |

## Verification
A wrong volume or rate state shows on `att_left`, `att_right`, `mute` or `dac_rate` two edges after the offending write, and on `rd_data` at the next read of that address. A lost default after a reset-word write shows only when a plain register is read back. For that reason the bench reads registers back right after a reset-word write, and again throughout a random mix of reads and writes. A wrongly gated rate write shows as a missing or spurious `reconfig` pulse at the same moment as the output change.

// File: rtl/codec_pkg.sv
package codec_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int ATT_W  = 5;
  localparam int NRATES = 7;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam idx_t IX_RESET  = 6'h00;
  localparam idx_t IX_MASTER = 6'h01;
  localparam idx_t IX_PCM    = 6'h0c;
  localparam idx_t IX_PWR    = 6'h13;
  localparam idx_t IX_EXTID  = 6'h14;
  localparam idx_t IX_EXTCTL = 6'h15;
  localparam idx_t IX_DAC    = 6'h16;
  localparam idx_t IX_ADC    = 6'h19;
  localparam idx_t IX_VEND1  = 6'h3e;
  localparam idx_t IX_VEND2  = 6'h3f;

  localparam word_t RESET_WORD  = 16'h6a90;
  localparam word_t EXTID_WORD  = 16'h0a05;
  localparam word_t EXTCTL_BASE = 16'h0400;
  localparam word_t VOL_MASK    = 16'h9f1f;
  localparam word_t MASTER_DEF  = 16'h8000;
  localparam word_t PCM_DEF     = 16'h8808;
  localparam word_t RATE_MAX    = 16'd48000;
  localparam logic [7:0] PWR_STATUS = 8'h0f;

  localparam word_t RATE_TAB [NRATES] =
    '{16'd8000, 16'd11025, 16'd16000, 16'd22050, 16'd32000, 16'd44100, 16'd48000};

  function automatic word_t snap_rate(word_t r);
    word_t res;
    logic  hit;
    res = RATE_MAX;
    hit = 1'b0;
    for (int i = 0; i < NRATES - 1; i++) begin
      if (!hit && (r < RATE_TAB[i] + ((RATE_TAB[i+1] - RATE_TAB[i]) >> 1))) begin
        res = RATE_TAB[i];
        hit = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic word_t master_fix(word_t d);
    word_t v;
    v = d;
    if (v[13]) v[12:8] = '1;
    if (v[5])  v[4:0]  = '1;
    return v & VOL_MASK;
  endfunction

  function automatic logic is_special(idx_t ix);
    case (ix)
      IX_RESET, IX_MASTER, IX_PCM, IX_PWR, IX_EXTID,
      IX_EXTCTL, IX_DAC, IX_ADC, IX_VEND1, IX_VEND2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic word_t plain_default(idx_t ix);
    case (ix)
      6'h02, 6'h03, 6'h0e:        return 16'h8000;
      6'h06, 6'h07:               return 16'h8008;
      6'h08, 6'h09, 6'h0a, 6'h0b: return 16'h8808;
      default:                    return 16'h0000;
    endcase
  endfunction

  function automatic logic [ATT_W-1:0] sat_sum(logic [ATT_W-1:0] a, logic [ATT_W-1:0] b);
    logic [ATT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ATT_W] ? '1 : s[ATT_W-1:0];
  endfunction
endpackage

// File: rtl/codec_plain_store.sv
module codec_plain_store #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rhit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;

  // RAM-style array: no reset, synchronous read
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end

  // written-since-reset flags; a clear makes every word show its default
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld <= '0;
    end else if (we) begin
      vld[widx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rhit <= 1'b0;
    else if (re) rhit <= vld[ridx];
  end
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  idx_t       wr_idx,
  input  word_t      wr_data,
  output word_t      master_q,
  output word_t      pcm_q,
  output logic [7:0] pwr_hi_q,
  output logic       vra_q,
  output word_t      dac_q,
  output word_t      adc_q,
  output logic       reconf_q
);
  logic restore;
  assign restore = rst || (wr_en && wr_idx == IX_RESET);

  always_ff @(posedge clk) begin
    reconf_q <= 1'b0;
    if (restore) begin
      master_q <= MASTER_DEF;
      pcm_q    <= PCM_DEF;
      pwr_hi_q <= 8'h00;
      vra_q    <= 1'b0;
      dac_q    <= RATE_MAX;
      adc_q    <= RATE_MAX;
      reconf_q <= !rst;
    end else if (wr_en) begin
      case (wr_idx)
        IX_MASTER: master_q <= master_fix(wr_data);
        IX_PCM:    pcm_q    <= wr_data & VOL_MASK;
        IX_PWR:    pwr_hi_q <= wr_data[15:8];
        IX_EXTCTL: begin
          vra_q <= wr_data[0];
          if (!wr_data[0]) begin
            dac_q    <= RATE_MAX;
            adc_q    <= RATE_MAX;
            reconf_q <= 1'b1;
          end
        end
        IX_DAC: if (vra_q) begin
          dac_q    <= snap_rate(wr_data);
          reconf_q <= 1'b1;
        end
        IX_ADC: if (vra_q) begin
          adc_q    <= snap_rate(wr_data);
          reconf_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/codec_out_stage.sv
module codec_out_stage
  import codec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  word_t            master,
  input  word_t            pcm,
  input  word_t            dac,
  input  logic             reconf_in,
  output logic [ATT_W-1:0] att_left,
  output logic [ATT_W-1:0] att_right,
  output logic             mute,
  output word_t            dac_rate,
  output logic             reconfig
);
  localparam int NCH = 2;
  localparam int LEFT_LSB  = 8;
  localparam int RIGHT_LSB = 0;

  logic [NCH*ATT_W-1:0] att_bus;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int LO = (ch == 0) ? LEFT_LSB : RIGHT_LSB;
    logic [ATT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= sat_sum(MASTER_DEF[LO +: ATT_W], PCM_DEF[LO +: ATT_W]);
      else     q <= sat_sum(master[LO +: ATT_W], pcm[LO +: ATT_W]);
    end
    assign att_bus[ch*ATT_W +: ATT_W] = q;
  end

  assign att_left  = att_bus[0 +: ATT_W];
  assign att_right = att_bus[ATT_W +: ATT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      mute     <= MASTER_DEF[15] | PCM_DEF[15];
      dac_rate <= RATE_MAX;
      reconfig <= 1'b0;
    end else begin
      mute     <= master[15] | pcm[15];
      dac_rate <= dac;
      reconfig <= reconf_in;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{master[14:13], master[7:5], pcm[14:13], pcm[7:5]};
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_pkg::*;
#(
  parameter logic [15:0] VEND_ID_HI = 16'h5a41,
  parameter logic [15:0] VEND_ID_LO = 16'h4301
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic [ATT_W-1:0]      att_left,
  output logic [ATT_W-1:0]      att_right,
  output logic                  mute,
  output logic [DATA_W-1:0]     dac_rate,
  output logic                  reconfig
);
  idx_t  idx;
  logic  wr, rd, spec;
  word_t master_q, pcm_q, dac_q, adc_q;
  logic [7:0] pwr_hi_q;
  logic  vra_q, reconf_q;
  word_t mem_q, spec_val, spec_q, dflt_q;
  logic  hit_q, plain_q;

  assign idx  = req_addr[ADDR_W-1:1];
  assign wr   = req_valid && req_write;
  assign rd   = req_valid && !req_write;
  assign spec = is_special(idx);

  logic unused_addr_lsb;
  assign unused_addr_lsb = req_addr[0];

  codec_plain_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clr   (wr && idx == IX_RESET),
    .we    (wr && !spec),
    .widx  (idx),
    .wdata (req_wdata),
    .re    (rd),
    .ridx  (idx),
    .rdata (mem_q),
    .rhit  (hit_q)
  );

  codec_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr),
    .wr_idx   (idx),
    .wr_data  (req_wdata),
    .master_q (master_q),
    .pcm_q    (pcm_q),
    .pwr_hi_q (pwr_hi_q),
    .vra_q    (vra_q),
    .dac_q    (dac_q),
    .adc_q    (adc_q),
    .reconf_q (reconf_q)
  );

  codec_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .master    (master_q),
    .pcm       (pcm_q),
    .dac       (dac_q),
    .reconf_in (reconf_q),
    .att_left  (att_left),
    .att_right (att_right),
    .mute      (mute),
    .dac_rate  (dac_rate),
    .reconfig  (reconfig)
  );

  always_comb begin
    case (idx)
      IX_RESET:  spec_val = RESET_WORD;
      IX_MASTER: spec_val = master_q;
      IX_PCM:    spec_val = pcm_q;
      IX_PWR:    spec_val = {pwr_hi_q, PWR_STATUS};
      IX_EXTID:  spec_val = EXTID_WORD;
      IX_EXTCTL: spec_val = EXTCTL_BASE | {{(DATA_W-1){1'b0}}, vra_q};
      IX_DAC:    spec_val = dac_q;
      IX_ADC:    spec_val = adc_q;
      IX_VEND1:  spec_val = VEND_ID_HI;
      IX_VEND2:  spec_val = VEND_ID_LO;
      default:   spec_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd;
  end

  always_ff @(posedge clk) begin
    if (rd) begin
      spec_q  <= spec_val;
      plain_q <= !spec;
      dflt_q  <= plain_default(idx);
    end
  end

  assign rd_data = plain_q ? (hit_q ? mem_q : dflt_q) : spec_q;
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic        rd_req,
  input logic        ctl_clr_req,
  input logic        rd_valid,
  input logic        mute,
  input logic [15:0] dac_rate,
  input logic        reconfig
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (dac_rate == 16'd48000 && mute && !reconfig && !rd_valid)); // R1

  AST_CLR_VRA_STROBE: assert property (@(posedge clk) disable iff (rst)
    ctl_clr_req |=> ##1 (reconfig && dac_rate == 16'd48000)); // R5

  AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (dac_rate inside {16'd8000, 16'd11025, 16'd16000, 16'd22050,
                      16'd32000, 16'd44100, 16'd48000})); // R7

  AST_RATE_CHANGE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_rate) |-> reconfig); // R7

  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R12

  AST_NO_READ_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid); // R12
endmodule

bind codec_regfile codec_regfile_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_req      (req_valid && !req_write),
  .ctl_clr_req (req_valid && req_write && req_addr[6:1] == 6'h15 && !req_wdata[0]),
  .rd_valid    (rd_valid),
  .mute        (mute),
  .dac_rate    (dac_rate),
  .reconfig    (reconfig)
);

// File: tb/codec_regfile_tb.sv
module codec_regfile_tb;
  localparam logic [15:0] VH = 16'h1357;
  localparam logic [15:0] VL = 16'h2468;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid, mute, reconfig;
  logic [15:0] rd_data, dac_rate;
  logic [4:0]  att_left, att_right;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] m [64];

  always #4 clk = ~clk;

  codec_regfile #(.VEND_ID_HI(VH), .VEND_ID_LO(VL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .att_left(att_left), .att_right(att_right),
    .mute(mute), .dac_rate(dac_rate), .reconfig(reconfig)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 64; i++) m[i] = 16'h0000;
    m[6'h00] = 16'h6a90;
    m[6'h01] = 16'h8000; m[6'h02] = 16'h8000; m[6'h03] = 16'h8000;
    m[6'h06] = 16'h8008; m[6'h07] = 16'h8008;
    m[6'h08] = 16'h8808; m[6'h09] = 16'h8808; m[6'h0a] = 16'h8808;
    m[6'h0b] = 16'h8808; m[6'h0c] = 16'h8808; m[6'h0e] = 16'h8000;
    m[6'h13] = 16'h000f; m[6'h14] = 16'h0a05; m[6'h15] = 16'h0400;
    m[6'h16] = 16'd48000; m[6'h19] = 16'd48000;
    m[6'h3e] = VH; m[6'h3f] = VL;
  endfunction

  function automatic logic [15:0] snap(logic [15:0] r);
    if (r < 16'd9512)  return 16'd8000;
    if (r < 16'd13512) return 16'd11025;
    if (r < 16'd19025) return 16'd16000;
    if (r < 16'd27025) return 16'd22050;
    if (r < 16'd38050) return 16'd32000;
    if (r < 16'd46050) return 16'd44100;
    return 16'd48000;
  endfunction

  function automatic bit model_write(int ix, logic [15:0] d);
    logic [15:0] v;
    bit rc = 0;
    case (ix)
      'h00: begin model_reset(); rc = 1; end
      'h01: begin
        v = d;
        if (v[13]) v[12:8] = 5'h1f;
        if (v[5])  v[4:0]  = 5'h1f;
        m[ix] = v & 16'h9f1f;
      end
      'h0c: m[ix] = d & 16'h9f1f;
      'h13: m[ix] = {d[15:8], 8'h0f};
      'h14, 'h3e, 'h3f: ;
      'h15: begin
        m[ix] = 16'h0400 | {15'd0, d[0]};
        if (!d[0]) begin m['h16] = 16'd48000; m['h19] = 16'd48000; rc = 1; end
      end
      'h16, 'h19: if (m['h15][0]) begin m[ix] = snap(d); rc = 1; end
      default: m[ix] = d;
    endcase
    return rc;
  endfunction

  function automatic logic [4:0] sat5(logic [4:0] a, logic [4:0] b);
    logic [5:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[5] ? 5'h1f : s[4:0];
  endfunction

  task automatic check_outs(string tag);
    check({tag, " R11 att_left"}, {27'd0, att_left}, {27'd0, sat5(m[1][12:8], m['h0c][12:8])});
    check({tag, " R11 att_right"}, {27'd0, att_right}, {27'd0, sat5(m[1][4:0], m['h0c][4:0])});
    check({tag, " R11 mute"}, {31'd0, mute}, {31'd0, m[1][15] | m['h0c][15]});
    check({tag, " R11 dac_rate"}, {16'd0, dac_rate}, {16'd0, m['h16]});
  endtask

  // called at a negedge; returns at a negedge
  task automatic do_write(logic [6:0] a, logic [15:0] d, string tag);
    bit rc;
    rc = model_write(int'(a[6:1]), d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    @(negedge clk);
    check({tag, " reconfig"}, {31'd0, reconfig}, {31'd0, rc});
    check_outs(tag);
  endtask

  task automatic do_read(logic [6:0] a, string tag);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check("R12 rd_valid", {31'd0, rd_valid}, 32'd1);
    check(tag, {16'd0, rd_data}, {16'd0, m[a[6:1]]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd12345));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reconfig", {31'd0, reconfig}, 32'd0);
    check("R12 rd_valid idle", {31'd0, rd_valid}, 32'd0);
    check_outs("R1");
    do_read(7'h02, "R1 master default");
    do_read(7'h18, "R1 pcm default");
    do_read(7'h10, "R1 line default");
    do_read(7'h0c, "R1 phone default");
    do_read(7'h26, "R1 powerdown default");
    do_read(7'h2a, "R1 extctl default");
    do_read(7'h2c, "R1 dac default");
    do_read(7'h00, "R2 reset word");
    do_read(7'h7c, "R9 vendor hi");
    @(negedge clk);
    check("R12 rd_valid drop", {31'd0, rd_valid}, 32'd0);

    do_write(7'h02, 16'h2020, "R3 replicate");
    do_read(7'h02, "R3 readback");
    do_write(7'h02, 16'h0a03, "R3 plain");
    do_read(7'h02, "R3 readback2");
    do_write(7'h18, 16'hffff, "R4 mask");
    do_read(7'h18, "R4 readback");
    do_write(7'h18, 16'h0000, "R4 unmute");
    do_write(7'h02, 16'h1010, "R11 saturate off");
    do_write(7'h2c, 16'd8000, "R6 rate ignored");
    do_read(7'h2c, "R6 readback");
    do_write(7'h2a, 16'hffff, "R5 set vra");
    do_read(7'h2a, "R5 readback");
    do_write(7'h2c, 16'd9511, "R7 below thr");
    do_write(7'h2c, 16'd9512, "R7 at thr");
    do_write(7'h2c, 16'd46049, "R7 44100 band");
    do_write(7'h2c, 16'd60000, "R7 clamp");
    do_write(7'h2c, 16'd0, "R7 zero");
    do_write(7'h32, 16'd20000, "R7 adc");
    do_read(7'h32, "R7 adc readback");
    do_write(7'h2a, 16'hfffe, "R5 clear vra");
    do_read(7'h32, "R5 adc forced");
    do_read(7'h2a, "R5 readback cleared");
    do_write(7'h26, 16'habcd, "R8 powerdown");
    do_read(7'h26, "R8 readback");
    do_write(7'h28, 16'h1111, "R9 extid write");
    do_read(7'h28, "R9 extid readback");
    do_write(7'h7e, 16'h2222, "R9 vendor write");
    do_read(7'h7e, "R9 vendor readback");
    do_write(7'h41, 16'hbeef, "R10 odd addr");
    do_read(7'h40, "R10 readback even");
    do_read(7'h41, "R10 readback odd");
    do_write(7'h10, 16'h1234, "R10 line");
    do_write(7'h00, 16'h5555, "R2 reset write");
    do_read(7'h10, "R2 line restored");
    do_read(7'h40, "R2 plain cleared");
    do_read(7'h02, "R2 master restored");
    do_read(7'h26, "R2 powerdown restored");

    for (int n = 0; n < 600; n++) begin
      int ix;
      logic [15:0] d;
      ix = int'($urandom_range(63));
      if (ix == 0 && ($urandom_range(7) != 0)) ix = 1;
      if (ix == 'h16 || ix == 'h19) d = 16'($urandom_range(60000));
      else d = 16'($urandom);
      if ($urandom_range(1) == 1)
        do_write({6'(ix), 1'($urandom_range(1))}, d, "R10 random write");
      else
        do_read({6'(ix), 1'($urandom_range(1))}, "R10 random read");
    end
    finish_run();
  end
endmodule